// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block guards an in-order five-stage integer pipeline against the one data dependency that forwarding cannot cover. That dependency arises when a load sits in execute and the instruction in decode reads the register the load is about to fill. In that case the detector stalls the pipeline. It holds the program counter and the decode register for one cycle and replaces the control word entering execute with all zeros. The dependent instruction then enters execute exactly one cycle late, behind a single bubble.

To make the stall visible over time, a thin wrapper also keeps three pieces of state: the program counter, the fetch-to-decode instruction register, and the execute-stage control word with its destination field. Instruction fetch is modelled as a combinational input that the surrounding environment drives from the current program counter.

Top module: `loaduse_stall_top`

## Requirements
- R1: `stall` is high in a cycle exactly when `exCtrl` has memRead set, `exRt` is nonzero, and `exRt` equals either source field of `decInstr`. The first source field is bits [25:21] and the second is bits [20:16]. The strobes follow `stall` in the same cycle: `pcWrEn` = `irWrEn` = not `stall`, and `bubbleSel` = `stall`.
- R2: When `pcWrEn` is low, `pcQ` keeps its value across the clock edge. Otherwise `pcQ` advances by PC_STEP on every edge.
- R3: When `irWrEn` is low, `decInstr` keeps its value across the clock edge, so the dependent instruction stays in decode. Otherwise `decInstr` loads `fetchInstr`.
- R4: On the edge after a stall cycle, `exCtrl` becomes all zeros.
- R5: A load whose `exRt` is register 0 never raises `stall`, even when a source field of `decInstr` is also 0.
- R6: A stall lasts exactly one cycle per load, and a dependent consumer reaches execute one cycle later than an independent one. Loads and non-loads whose destination field the consumer does not read cost zero cycles. A store or branch in execute (memRead clear) never stalls.
- R7: For the sequence lw $2 / and $4,$2,$5 / or $8,$2,$6, the and is held in decode for one cycle, and the or then passes through decode without a stall.
- R8: Control bits are decoded from opcode bits [31:26] and packed into `exCtrl` as {regDst, aluOp[1:0], aluSrc, branch, memRead, memWrite, regWrite, memToReg}. The opcodes decode as follows:
  - Opcode 0 (register format) gives 1_10_0_0_0_0_1_0.
  - Opcode 35 (load) gives 0_00_1_0_1_0_1_1.
  - Opcode 43 (store) gives 0_00_1_0_0_1_0_0.
  - Opcode 4 (branch equal) gives 0_01_0_1_0_0_0_0.
  - Any other opcode gives all zeros.
- R9: While `rstN` is low, `pcQ` is RESET_PC and `decInstr`, `exCtrl` and `exRt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchInstr | input | 32 | Instruction fetched at `pcQ` |
| pcQ | output | PC_W | Program counter |
| decInstr | output | 32 | Instruction held in decode |
| exCtrl | output | 9 | Control word held for execute |
| exRt | output | 5 | Destination field of the instruction in execute |
| pcWrEn | output | 1 | Program counter write enable |
| irWrEn | output | 1 | Decode register write enable |
| bubbleSel | output | 1 | Selects the all-zero control word for execute |
| stall | output | 1 | Load-use hazard detected this cycle |

## Verification
The bench builds the block with PC_W = 12, PC_STEP = 4 and RESET_PC = 0. With these values a small word-indexed instruction store in the bench can be addressed straight from `pcQ`, and every held or advanced program-counter value is an exact multiple of four that is easy to predict. The narrow counter still leaves room for back-to-back loads and three-instruction sequences. The register-0 exclusion, match on either source field, and store-or-branch cases are all within reach of the same producer/consumer table.

// File: rtl/lu_pkg.sv
package lu_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OPC_W   = 6;
  localparam int NUM_SRC = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
    logic       branch;
    logic       memRead;
    logic       memWrite;
    logic       regWrite;
    logic       memToReg;
  } exCtrl_t;

  localparam int CTRL_W = $bits(exCtrl_t);

  typedef struct packed {
    logic pcWrEn;
    logic irWrEn;
    logic bubbleSel;
  } hazStrobe_t;

  function automatic exCtrl_t decodeCtrl(input logic [OPC_W-1:0] opc);
    exCtrl_t c;
    c = '0;
    unique case (opc)
      OPC_RTYPE: begin
        c.regDst = 1'b1; c.aluOp = 2'b10; c.regWrite = 1'b1;
      end
      OPC_LOAD: begin
        c.aluSrc = 1'b1; c.memRead = 1'b1; c.regWrite = 1'b1; c.memToReg = 1'b1;
      end
      OPC_STORE: begin
        c.aluSrc = 1'b1; c.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        c.aluOp = 2'b01; c.branch = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lu_datapath.sv
module lu_datapath
  import lu_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  hazStrobe_t          strobe,
  input  logic [INSTR_W-1:0]  fetchInstr,
  output logic [PC_W-1:0]     pcQ,
  output logic [INSTR_W-1:0]  decInstr,
  output exCtrl_t             exCtrl,
  output logic [REG_W-1:0]    exRt,
  output logic [REG_W-1:0]    decRs,
  output logic [REG_W-1:0]    decRt
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam logic [PC_W-1:0] STEP_V  = PC_W'(PC_STEP);
  localparam logic [PC_W-1:0] RESET_V = PC_W'(RESET_PC);

  exCtrl_t idCtrl;

  assign decRs = decInstr[RS_LSB +: REG_W];
  assign decRt = decInstr[RT_LSB +: REG_W];

  always_comb idCtrl = decodeCtrl(decInstr[OPC_LSB +: OPC_W]);

  // program counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pcQ <= RESET_V;
    else if (strobe.pcWrEn)  pcQ <= pcQ + STEP_V;
  end

  // fetch-to-decode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               decInstr <= '0;
    else if (strobe.irWrEn)  decInstr <= fetchInstr;
  end

  // decode-to-execute control word and destination field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exCtrl <= '0;
      exRt   <= '0;
    end else begin
      exCtrl <= strobe.bubbleSel ? exCtrl_t'('0) : idCtrl;
      exRt   <= decRt;
    end
  end

  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pcWrEn |=> pcQ == $past(pcQ));

  a_r4_bubble_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bubbleSel |=> exCtrl == '0);

endmodule

// File: rtl/lu_hazard_ctrl.sv
module lu_hazard_ctrl
  import lu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] decSrc [NUM_SRC],
  output hazStrobe_t       strobe,
  output logic             stall
);

  logic [NUM_SRC-1:0] srcHit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcHit[i] = (decSrc[i] == exRt);
  end

  assign stall = exMemRead && (exRt != '0) && (|srcHit);

  always_comb begin
    strobe.pcWrEn    = !stall;
    strobe.irWrEn    = !stall;
    strobe.bubbleSel = stall;
  end

  a_r5_no_zero_stall: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> exRt != '0);

  a_r1_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> exMemRead);

endmodule

// File: rtl/loaduse_stall_top.sv
module loaduse_stall_top
  import lu_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int unsigned PC_STEP  = 4,
  parameter int unsigned RESET_PC = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        fetchInstr,
  output logic [PC_W-1:0]    pcQ,
  output logic [31:0]        decInstr,
  output logic [8:0]         exCtrl,
  output logic [4:0]         exRt,
  output logic               pcWrEn,
  output logic               irWrEn,
  output logic               bubbleSel,
  output logic               stall
);

  hazStrobe_t       strobe;
  exCtrl_t          exCtrlS;
  logic [REG_W-1:0] decRs;
  logic [REG_W-1:0] decRt;
  logic [REG_W-1:0] decSrc [NUM_SRC];

  assign decSrc[0] = decRs;
  assign decSrc[1] = decRt;

  lu_datapath #(
    .PC_W(PC_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchInstr(fetchInstr),
    .pcQ(pcQ), .decInstr(decInstr), .exCtrl(exCtrlS), .exRt(exRt),
    .decRs(decRs), .decRt(decRt)
  );

  lu_hazard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .exMemRead(exCtrlS.memRead), .exRt(exRt),
    .decSrc(decSrc), .strobe(strobe), .stall(stall)
  );

  assign exCtrl    = exCtrlS;
  assign pcWrEn    = strobe.pcWrEn;
  assign irWrEn    = strobe.irWrEn;
  assign bubbleSel = strobe.bubbleSel;

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  a_r3_decode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !irWrEn |=> $stable(decInstr));

endmodule

// File: tb/loaduse_stall_top_bench.sv
module loaduse_stall_top_bench;

  localparam int PC_W = 12;
  localparam int NV   = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchInstr;
  logic [PC_W-1:0] pcQ;
  logic [31:0] decInstr;
  logic [8:0]  exCtrl;
  logic [4:0]  exRt;
  logic        pcWrEn, irWrEn, bubbleSel, stall;

  logic [31:0] imem [16];
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  always_comb fetchInstr = imem[pcQ[5:2]];

  loaduse_stall_top #(.PC_W(PC_W), .PC_STEP(4), .RESET_PC(0)) u_loaduse_stall_top (
    .clk(clk), .rstN(rstN), .fetchInstr(fetchInstr), .pcQ(pcQ),
    .decInstr(decInstr), .exCtrl(exCtrl), .exRt(exRt), .pcWrEn(pcWrEn),
    .irWrEn(irWrEn), .bubbleSel(bubbleSel), .stall(stall)
  );

  // vector: {producer opcode, producer rt, consumer opcode, consumer rs, consumer rt}
  localparam logic [26:0] VEC [NV] = '{
    {6'd35, 5'd2,  6'd0,  5'd2,  5'd5},   // load -> rs match
    {6'd35, 5'd2,  6'd0,  5'd5,  5'd2},   // load -> rt match
    {6'd35, 5'd0,  6'd0,  5'd0,  5'd0},   // load to $0
    {6'd43, 5'd2,  6'd0,  5'd2,  5'd5},   // store in execute
    {6'd0,  5'd2,  6'd0,  5'd2,  5'd2},   // register-format producer
    {6'd35, 5'd7,  6'd0,  5'd2,  5'd3},   // independent
    {6'd35, 5'd3,  6'd43, 5'd1,  5'd3},   // store data depends on load
    {6'd35, 5'd31, 6'd4,  5'd31, 5'd9},   // branch depends on load
    {6'd35, 5'd4,  6'd35, 5'd4,  5'd6},   // load address depends on load
    {6'd4,  5'd2,  6'd0,  5'd2,  5'd1}    // branch in execute
  };

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] low);
    return {opc, rs, rt, low};
  endfunction

  // R8 expected control word
  function automatic logic [8:0] expCtrl(input logic [5:0] opc);
    case (opc)
      6'd0:    return 9'b1_10_0_0_0_0_1_0;
      6'd35:   return 9'b0_00_1_0_1_0_1_1;
      6'd43:   return 9'b0_00_1_0_0_1_0_0;
      6'd4:    return 9'b0_01_0_1_0_0_0_0;
      default: return 9'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 16; i++) imem[i] = 32'h0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    clearMem();
    // R9 reset state
    @(negedge clk);
    check(pcQ == 0, "R9 pc", 64'(pcQ), 0);
    check(decInstr == 0, "R9 decInstr", 64'(decInstr), 0);
    check(exCtrl == 0, "R9 exCtrl", 64'(exCtrl), 0);
    check(exRt == 0, "R9 exRt", 64'(exRt), 0);

    // vector table walk: R1..R6, R8
    for (int v = 0; v < NV; v++) begin
      logic [5:0] pOpc, cOpc;
      logic [4:0] pRt, cRs, cRt;
      logic [31:0] cIns;
      bit expStall;
      {pOpc, pRt, cOpc, cRs, cRt} = VEC[v];
      cIns = mk(cOpc, cRs, cRt, 16'h1820);
      rstN = 1'b0;
      clearMem();
      imem[0] = mk(pOpc, 5'd1, pRt, 16'h0014);
      imem[1] = cIns;
      expStall = (pOpc == 6'd35) && (pRt != 0) && (pRt == cRs || pRt == cRt);
      doReset();
      step();
      step();
      check(stall == expStall, "R1 stall", 64'(stall), 64'(expStall));
      check(pcWrEn == !expStall && irWrEn == !expStall && bubbleSel == expStall,
            "R1 strobes", {pcWrEn, irWrEn, bubbleSel}, {!expStall, !expStall, expStall});
      check(exCtrl == expCtrl(pOpc), "R8 producer ctrl", 64'(exCtrl), 64'(expCtrl(pOpc)));
      step();
      if (expStall) begin
        check(pcQ == 8, "R2 pc held", 64'(pcQ), 8);
        check(decInstr == cIns, "R3 decode held", 64'(decInstr), 64'(cIns));
        check(exCtrl == 0, "R4 bubble", 64'(exCtrl), 0);
        check(stall == 0, "R6 single stall", 64'(stall), 0);
        step();
        check(exCtrl == expCtrl(cOpc), "R6 consumer one late", 64'(exCtrl),
              64'(expCtrl(cOpc)));
        check(pcQ == 12, "R2 pc resumes", 64'(pcQ), 12);
      end else begin
        check(pcQ == 12, "R2 pc advances", 64'(pcQ), 12);
        check(exCtrl == expCtrl(cOpc), "R6 zero penalty", 64'(exCtrl),
              64'(expCtrl(cOpc)));
        if (pRt == 0) check(stall == 0, "R5 reg0 no stall", 64'(stall), 0);
      end
    end

    // R7 lw $2 / and $4,$2,$5 / or $8,$2,$6
    rstN = 1'b0;
    clearMem();
    imem[0] = mk(6'd35, 5'd1, 5'd2, 16'd20);
    imem[1] = mk(6'd0, 5'd2, 5'd5, {5'd4, 11'h024});
    imem[2] = mk(6'd0, 5'd2, 5'd6, {5'd8, 11'h025});
    doReset();
    step();
    step();
    check(stall == 1, "R7 and stalls", 64'(stall), 1);
    step();
    check(stall == 0 && decInstr == imem[1], "R7 and held one cycle",
          {stall, decInstr}, {1'b0, imem[1]});
    step();
    check(decInstr == imem[2] && stall == 0, "R7 or no stall",
          {stall, decInstr}, {1'b0, imem[2]});
    step();
    check(pcQ == 16 && stall == 0, "R7 pc after sequence", {stall, 52'(pcQ)}, 16);

    // R6 back-to-back loads: each stall one cycle
    rstN = 1'b0;
    clearMem();
    imem[0] = mk(6'd35, 5'd1, 5'd2, 16'd0);
    imem[1] = mk(6'd35, 5'd2, 5'd3, 16'd0);
    imem[2] = mk(6'd0, 5'd3, 5'd3, 16'h2020);
    doReset();
    step();
    step();
    check(stall == 1, "R6 first load stall", 64'(stall), 1);
    step();
    check(stall == 0, "R6 first stall ends", 64'(stall), 0);
    step();
    check(stall == 1, "R6 second load stall", 64'(stall), 1);
    step();
    check(stall == 0 && pcQ == 12, "R6 second stall ends", {stall, 52'(pcQ)}, 12);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule